// File: doc/BRIEF.md
# Strided Memory Aperture Address Translator

This block sits beside an 8-bit host's 16-bit address bus. For each access it decides whether the address falls in a programmable window of 256-byte host pages. When it does, the access is redirected from on-board RAM to a large backing memory, and the block computes the 25-bit physical byte address to use there.

The host loads a small descriptor through a byte-wide write port. The descriptor holds a window start page, a page count, a backing base address, a stride in pages per line and a line width in bytes. With a zero width or a zero stride, the window is a plain linear remap. Otherwise the window offset is split into a row and a column by the line width. The row is then scaled by the stride times 256, so that a short host line can show part of a longer virtual line in backing memory.

The division is done one quotient bit per cycle. Each request is answered by a one-cycle response pulse. The descriptor is copied as one set when a request is accepted, so a host update made while a request is in flight never mixes old and new fields.

Top module: `aperture_xlate`

## Requirements
- R1: After a synchronous reset, `busy` and `rsp_valid` are low.
- R2: A descriptor byte is written when `cfg_we` is high, at index `cfg_addr`. The indices are: 0 window start page, 1 page count, 2 stride (pages per line), 3 line width low byte, 4 line width high byte, 5 to 8 base address bytes, least significant first. Base bits at or above bit 25 are discarded, and other indices are ignored.
- R3: A request hits when its page (address bits 15:8) is at least the start page and below start page plus page count. The sum is computed without 8-bit wrap, so a page count of 0 never hits.
- R4: A miss responds with `rsp_hit` low and `rsp_paddr` zero.
- R5: On a hit with width 0 or stride 0, `rsp_paddr` is base plus offset, where offset = address − start page × 256.
- R6: On a hit with nonzero width and stride, `rsp_paddr` = base + (offset / width) × stride × 256 + (offset mod width).
- R7: Physical addresses wrap modulo 2^25.
- R8: A request is taken only while `busy` is low, and a request presented while busy is ignored. Each accepted request yields exactly one single-cycle `rsp_valid` pulse, during which `busy` is low.
- R9: The descriptor used by a request is the one present when it was accepted. Writes made while it is in flight affect only later requests.
- R10: Adding 1 to the base moves every translated address by +1. Adding stride × 256 moves it by one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor byte write strobe |
| cfg_addr | input | 4 | Descriptor byte index |
| cfg_wdata | input | 8 | Descriptor byte value |
| req_valid | input | 1 | Translation request |
| req_addr | input | 16 | Host address to translate |
| busy | output | 1 | A request is in flight |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access falls in the window |
| rsp_paddr | output | 25 | Physical backing address |

## Verification
The hardest situation to reach is a descriptor change that arrives while a strided request is still dividing. The bench starts a strided translation, waits until `busy` shows the divider is running, and then rewrites the base bytes. It expects the old result for that request and the new result for the next one. The same long busy window is used to present a stray request, which must produce no response. Edge cases on row and column boundaries, the top page of the address space, a zero page count and 25-bit wrap are reached by reprogramming the descriptor between request groups.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  parameter int ADDR_W  = 16;
  parameter int PAGE_SH = 8;
  parameter int PG_W    = ADDR_W - PAGE_SH;
  parameter int WID_W   = 16;
  parameter int PHYS_W  = 25;
  parameter int BASE_IX = 5;

  typedef struct packed {
    logic [PHYS_W-1:0] base;
    logic [PG_W-1:0]   start;
    logic [PG_W-1:0]   count;
    logic [PG_W-1:0]   stride;
    logic [WID_W-1:0]  width;
  } desc_t;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_DIV} xl_state_t;
endpackage

// File: rtl/aperture_desc_regs.sv
module aperture_desc_regs
  import aperture_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] idx,
  input  logic [7:0] wdata,
  input  logic       load,
  output desc_t      act
);
  desc_t stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else if (we) begin
      case (idx)
        4'd0: stg.start  <= wdata;
        4'd1: stg.count  <= wdata;
        4'd2: stg.stride <= wdata;
        4'd3: stg.width[7:0]  <= wdata;
        4'd4: stg.width[15:8] <= wdata;
        default: ;
      endcase
      for (int b = 0; b < PHYS_W; b++) begin
        if (int'(idx) == BASE_IX + b / 8) stg.base[b] <= wdata[b % 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       act <= '0;
    else if (load) act <= stg;
  end
endmodule

// File: rtl/aperture_divider.sv
module aperture_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] div_q;
  logic [W-1:0] dvd_q;
  logic [CW-1:0] cnt;
  logic         run;
  logic [W:0]   trial;

  assign trial = {rem, quo[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; done <= 1'b0; cnt <= '0;
      quo <= '0; rem <= '0; div_q <= '0; dvd_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1; cnt <= CW'(W);
        quo <= dividend; rem <= '0;
        div_q <= divisor; dvd_q <= dividend;
      end else if (run) begin
        if (trial >= {1'b0, div_q}) begin
          rem <= W'(trial - {1'b0, div_q});
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0; done <= 1'b1;
        end
      end
    end
  end

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> rem < div_q);

  // R6
  div_identity_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ({W'(0), quo} * {W'(0), div_q} + {W'(0), rem}) == {W'(0), dvd_q});
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import aperture_pkg::*;
#(
  parameter int P_W = PHYS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [P_W-1:0]    rsp_paddr
);
  localparam int RS_W = P_W - PAGE_SH;

  xl_state_t         state;
  desc_t             act;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic [PG_W:0]     page_end;
  logic              hit;
  logic              linear;
  logic [ADDR_W-1:0] offset;
  logic              div_start;
  logic              div_done;
  logic [WID_W-1:0]  quo;
  logic [WID_W-1:0]  rem;
  logic [RS_W-1:0]   row_scaled;

  assign busy   = (state != S_IDLE);
  assign accept = req_valid && !busy;

  aperture_desc_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_addr),
    .wdata(cfg_wdata), .load(accept), .act(act)
  );

  assign page_end  = {1'b0, act.start} + {1'b0, act.count};
  assign hit       = (addr_q[ADDR_W-1:PAGE_SH] >= act.start) &&
                     ({1'b0, addr_q[ADDR_W-1:PAGE_SH]} < page_end);
  assign linear    = (act.width == '0) || (act.stride == '0);
  assign offset    = addr_q - {act.start, {PAGE_SH{1'b0}}};
  assign div_start = (state == S_CHECK) && hit && !linear;

  aperture_divider #(.W(WID_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dividend(offset),
    .divisor(act.width), .done(div_done), .quo(quo), .rem(rem)
  );

  assign row_scaled = RS_W'(quo) * RS_W'(act.stride);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; addr_q <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (!hit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b0; rsp_paddr <= '0;
            state <= S_IDLE;
          end else if (linear) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1;
            rsp_paddr <= act.base + P_W'(offset);
            state <= S_IDLE;
          end else begin
            state <= S_DIV;
          end
        end
        S_DIV: if (div_done) begin
          rsp_valid <= 1'b1; rsp_hit <= 1'b1;
          rsp_paddr <= act.base + {row_scaled, {PAGE_SH{1'b0}}} + P_W'(rem);
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(act));
endmodule

// File: tb/aperture_xlate_tb.sv
`timescale 1ns/1ps
module aperture_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        busy, rsp_valid, rsp_hit;
  logic [24:0] rsp_paddr;

  always #2.5 clk = ~clk;

  aperture_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
  );

  typedef struct { logic hit; logic [24:0] pa; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, sent = 0, got = 0;
  longint m_start = 0, m_count = 0, m_stride = 0, m_width = 0, m_base = 0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = 8'(val);
    @(negedge clk); cfg_we = 1'b0;
    case (idx)  // R2 byte map
      0: m_start = val; 1: m_count = val; 2: m_stride = val;
      3: m_width = (m_width & 'hFF00) | val;
      4: m_width = (m_width & 'h00FF) | (val << 8);
      5, 6, 7, 8: m_base = (m_base & ~(longint'('hFF) << (8*(idx-5)))) |
                           (longint'(val) << (8*(idx-5)));
      default: ;
    endcase
  endtask

  task automatic set_desc(input longint st, input longint cn, input longint sd,
                          input longint wd, input longint bs);
    wr(0, int'(st)); wr(1, int'(cn)); wr(2, int'(sd));
    wr(3, int'(wd & 'hFF)); wr(4, int'((wd >> 8) & 'hFF));
    for (int i = 0; i < 4; i++) wr(5 + i, int'((bs >> (8*i)) & 'hFF));
  endtask

  task automatic send(input int a, input string tag);
    exp_t e;
    longint pg, off, pa;
    pg = a >> 8;
    e.tag = tag;
    e.hit = (pg >= m_start) && (pg < m_start + m_count);
    off = a - m_start * 256;
    if (!e.hit) pa = 0;
    else if (m_width == 0 || m_stride == 0) pa = m_base + off;
    else pa = m_base + (off / m_width) * m_stride * 256 + (off % m_width);
    e.pa = 25'(pa & 'h1FFFFFF);
    @(negedge clk);
    while (busy) @(negedge clk);
    q.push_back(e); sent++;
    req_valid = 1'b1; req_addr = 16'(a);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      got++;
      if (q.size() == 0) check(1'b0, "R8 unexpected response act=1 exp=0");
      else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_hit == e.hit && rsp_paddr == e.pa,
              $sformatf("%s act hit=%0d pa=%h exp hit=%0d pa=%h",
                        e.tag, rsp_hit, rsp_paddr, e.hit, e.pa));
      end
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rsp_valid, $sformatf("R1 reset act busy=%0d v=%0d exp 0 0", busy, rsp_valid));

    // linear window, R3 R4 R5
    set_desc('h40, 8, 0, 0, 'h123400);
    send('h4000, "R5 first byte");
    send('h47FF, "R5 last byte");
    send('h4800, "R3 above window");
    send('h3FFF, "R4 below window");
    drain();
    // width set but stride zero still linear (R5)
    wr(3, 40); send('h4123, "R5 stride zero");
    drain();

    // strided R6
    set_desc('h80, 'h10, 4, 40, 'h10000);
    send('h8000, "R6 origin");
    send('h8027, "R6 last column");
    send('h8028, "R6 second row");
    send('h8FFF, "R6 window end");
    drain();
    // R10 base +1 and +stride*256
    wr(5, 1); send('h8028, "R10 base plus one");
    drain();
    wr(5, 0); wr(6, 4); send('h8000, "R10 base plus line");
    drain();
    // width 1: every byte its own row
    set_desc('h20, 2, 3, 1, 'h500);
    send('h2005, "R6 width one");
    drain();

    // wrap R7, base upper bits discarded R2
    set_desc(0, 1, 0, 0, 'hFF_FFFF_F0);
    send('h0020, "R7 wrap linear");
    drain();
    set_desc(0, 4, 2, 'h100, 'h1FF_FF00);
    send('h0300, "R7 wrap strided");
    drain();

    // top of address space and empty window R3
    set_desc('hF0, 'h20, 0, 0, 'h2000);
    send('hFFFF, "R3 top page");
    send('hEFFF, "R3 below top window");
    drain();
    wr(1, 0); send('hF000, "R3 zero count");
    drain();

    // R9 snapshot: rewrite base while dividing
    set_desc('h10, 4, 2, 7, 'h40000);
    send('h1100, "R9 in flight old base");
    check(busy, "R9 setup act busy=0 exp=1");
    wr(5, 'h77);
    send('h1100, "R9 next request new base");
    drain();

    // R8 stray request while busy is ignored
    send('h1050, "R8 accepted request");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h1060;
    @(negedge clk); req_valid = 1'b0;
    drain();
    repeat (30) @(negedge clk);
    check(got == sent, $sformatf("R8 response count act=%0d exp=%0d", got, sent));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule